// File: doc/BRIEF.md
# Immediate Fused-Operation Execute Unit

This unit is the execute step for the immediate-operand instructions of an 8-bit accumulator processor. Each of these opcodes joins two basic steps into one: a bitwise AND followed by a shift or a rotate, an AND of the two registers followed by a subtraction into the index register, or a single load into both registers. The core supplies the opcode byte, the immediate byte, the current accumulator and index values, and the five status bits. The unit returns new register values, new status bits, a code that tells which registers to write back, and a flag for opcodes it does not recognise.

A start strobe samples every input on a rising edge. The result appears at the outputs on the second rising edge after that, together with a done pulse that lasts one cycle. The outputs then hold until the next result. Starts may be issued on back-to-back cycles, and each one gets its own result. Arithmetic is always binary. The decimal bit is carried through but has no effect.

Top module: `imm_fused_alu`

## Requirements
- R1: Opcodes 0x0B and 0x2B set A = A & M. N is A bit 7 and Z is (A == 0). C is set equal to the new N. V passes through unchanged. X is unchanged. dest_sel is 2'b01 (write A).
- R2: Opcode 0x4B sets A = (A & M) >> 1. C takes bit 0 of the AND. N is forced to 0 and Z is (A == 0). V passes through unchanged. dest_sel is 2'b01.
- R3: Opcode 0x6B sets A = {C_in, (A & M)[7:1]}. N is A bit 7 and Z is (A == 0). C is A bit 6. V is A bit 6 XOR A bit 5. dest_sel is 2'b01.
- R4: Opcode 0xCB sets X = (A & X) - M with no borrow-in. C is 1 when (A & X) >= M. N and Z follow the new X. V and A are unchanged. dest_sel is 2'b10 (write X).
- R5: Opcode 0xEB sets A = A - M - (1 - C_in). C is the no-borrow bit. V is signed overflow. N and Z follow the new A. dest_sel is 2'b01.
- R6: Opcode 0xAB loads M into both A and X. N and Z follow M. V and C are unchanged. dest_sel is 2'b11 (write both).
- R7: Any other opcode sets illegal to 1 and dest_sel to 2'b00. A, X and all five status bits come out equal to their inputs.
- R8: The D bit comes out equal to D_in for every opcode. D_in never changes the arithmetic.
- R9: Inputs are sampled only on the edge where start is high. Results and done appear on the second rising edge after that edge. done is high for exactly one cycle per start, and back-to-back starts each produce their own result on consecutive cycles.
- R10: While rst_n is low, every output is 0, including done, illegal and dest_sel.
- R11: Between completions, the outputs keep the last result whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Samples the inputs and begins an operation |
| opcode | input | 8 | Instruction byte |
| operand | input | DATA_W | Immediate byte M |
| acc_in | input | DATA_W | Current accumulator |
| idx_in | input | DATA_W | Current index register |
| flag_n_in | input | 1 | Incoming negative bit |
| flag_v_in | input | 1 | Incoming overflow bit |
| flag_d_in | input | 1 | Incoming decimal bit |
| flag_z_in | input | 1 | Incoming zero bit |
| flag_c_in | input | 1 | Incoming carry bit |
| acc_out | output | DATA_W | New accumulator |
| idx_out | output | DATA_W | New index register |
| flag_n_out | output | 1 | New negative bit |
| flag_v_out | output | 1 | New overflow bit |
| flag_d_out | output | 1 | Decimal bit, passed through |
| flag_z_out | output | 1 | New zero bit |
| flag_c_out | output | 1 | New carry bit |
| dest_sel | output | 2 | Write-back select: 00 none, 01 A, 10 X, 11 both |
| illegal | output | 1 | Opcode not in the set |
| done | output | 1 | One-cycle completion pulse |

## Verification
The test vectors cover both rotate cases that separate correct from wrong flag rules. One rotate result needs V set from bits 6 and 5. The other has a carry-in of 1, so it lands in the top bit; a unit that shifted in zero would produce 0x7F. The register-subtract cases include a borrow (X goes to 0xFF with C clear) and an exact match (zero with C set); a unit that ignored the AND with X, or reused the carry-in, would return a wrong X or C there. The alternate subtract is tested with a signed overflow and with C_in clear, which catches an inverted borrow sense. The right-shift opcode is run with N set on input, to catch a unit that passes N through. Unknown opcodes must leave every value as it came in. The inputs are scrambled right after start, and two starts are issued back to back; either would expose a unit that samples late or drops an operation.

// File: rtl/imm_alu_pkg.sv
package imm_alu_pkg;

   localparam int OPC_W = 8;

   localparam logic [OPC_W-1:0] OPC_ANC_A   = 8'h0B;
   localparam logic [OPC_W-1:0] OPC_ANC_B   = 8'h2B;
   localparam logic [OPC_W-1:0] OPC_ASR     = 8'h4B;
   localparam logic [OPC_W-1:0] OPC_ARR     = 8'h6B;
   localparam logic [OPC_W-1:0] OPC_LAX     = 8'hAB;
   localparam logic [OPC_W-1:0] OPC_SBX     = 8'hCB;
   localparam logic [OPC_W-1:0] OPC_SBC_ALT = 8'hEB;

   typedef enum logic [1:0] {
      DST_NONE = 2'b00,
      DST_ACC  = 2'b01,
      DST_IDX  = 2'b10,
      DST_BOTH = 2'b11
   } dest_e;

   typedef struct packed {
      logic n;
      logic v;
      logic d;
      logic z;
      logic c;
   } flags_t;

endpackage

// File: rtl/imm_alu_capture.sv
module imm_alu_capture
   import imm_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [OPC_W-1:0]    opc_i,
   input  logic [DATA_W-1:0]   opnd_i,
   input  logic [DATA_W-1:0]   acc_i,
   input  logic [DATA_W-1:0]   idx_i,
   input  flags_t              flags_i,
   output logic                valid_o,
   output logic [OPC_W-1:0]    opc_o,
   output logic [DATA_W-1:0]   opnd_o,
   output logic [DATA_W-1:0]   acc_o,
   output logic [DATA_W-1:0]   idx_o,
   output flags_t              flags_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         opc_o   <= '0;
         opnd_o  <= '0;
         acc_o   <= '0;
         idx_o   <= '0;
         flags_o <= '0;
      end else begin
         valid_o <= start_i;
         if (start_i) begin
            opc_o   <= opc_i;
            opnd_o  <= opnd_i;
            acc_o   <= acc_i;
            idx_o   <= idx_i;
            flags_o <= flags_i;
         end
      end
   end

endmodule

// File: rtl/imm_alu_sub.sv
module imm_alu_sub #(
   parameter int DATA_W      = 8,
   parameter bit SUB_VIA_ADD = 1'b1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              borrow_i,
   output logic [DATA_W-1:0] diff_o,
   output logic              no_borrow_o
);

   localparam int EXT_W = DATA_W + 1;

   generate
      if (SUB_VIA_ADD) begin : g_add
         logic [EXT_W-1:0] sum;
         assign sum         = {1'b0, a_i} + {1'b0, ~b_i} + {{DATA_W{1'b0}}, ~borrow_i};
         assign diff_o      = sum[DATA_W-1:0];
         assign no_borrow_o = sum[DATA_W];
      end else begin : g_sub
         logic [EXT_W-1:0] dif;
         assign dif         = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, borrow_i};
         assign diff_o      = dif[DATA_W-1:0];
         assign no_borrow_o = ~dif[DATA_W];
      end
   endgenerate

endmodule

// File: rtl/imm_alu_core.sv
module imm_alu_core
   import imm_alu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit SUB_VIA_ADD = 1'b1
) (
   input  logic [OPC_W-1:0]  opc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] idx_i,
   input  flags_t            flags_i,
   output logic [DATA_W-1:0] acc_o,
   output logic [DATA_W-1:0] idx_o,
   output flags_t            flags_o,
   output dest_e             dest_o,
   output logic              illegal_o
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] and_am;
   logic [DATA_W-1:0] and_ax;
   logic [DATA_W-1:0] shr_v;
   logic [DATA_W-1:0] rot_v;
   logic [DATA_W-1:0] sbx_diff;
   logic              sbx_nob;
   logic [DATA_W-1:0] sbc_diff;
   logic              sbc_nob;

   assign and_am = acc_i & opnd_i;
   assign and_ax = acc_i & idx_i;
   assign shr_v  = {1'b0, and_am[MSB:1]};
   assign rot_v  = {flags_i.c, and_am[MSB:1]};

   imm_alu_sub #(.DATA_W(DATA_W), .SUB_VIA_ADD(SUB_VIA_ADD)) u_sbx_sub (
      .a_i         (and_ax),
      .b_i         (opnd_i),
      .borrow_i    (1'b0),
      .diff_o      (sbx_diff),
      .no_borrow_o (sbx_nob)
   );

   imm_alu_sub #(.DATA_W(DATA_W), .SUB_VIA_ADD(SUB_VIA_ADD)) u_sbc_sub (
      .a_i         (acc_i),
      .b_i         (opnd_i),
      .borrow_i    (~flags_i.c),
      .diff_o      (sbc_diff),
      .no_borrow_o (sbc_nob)
   );

   always_comb begin
      acc_o     = acc_i;
      idx_o     = idx_i;
      flags_o   = flags_i;
      dest_o    = DST_NONE;
      illegal_o = 1'b0;
      case (opc_i)
         OPC_ANC_A, OPC_ANC_B: begin
            acc_o     = and_am;
            flags_o.n = and_am[MSB];
            flags_o.z = ~|and_am;
            flags_o.c = and_am[MSB];
            dest_o    = DST_ACC;
         end
         OPC_ASR: begin
            acc_o     = shr_v;
            flags_o.n = 1'b0;
            flags_o.z = ~|shr_v;
            flags_o.c = and_am[0];
            dest_o    = DST_ACC;
         end
         OPC_ARR: begin
            acc_o     = rot_v;
            flags_o.n = rot_v[MSB];
            flags_o.z = ~|rot_v;
            flags_o.c = rot_v[MSB-1];
            flags_o.v = rot_v[MSB-1] ^ rot_v[MSB-2];
            dest_o    = DST_ACC;
         end
         OPC_SBX: begin
            idx_o     = sbx_diff;
            flags_o.n = sbx_diff[MSB];
            flags_o.z = ~|sbx_diff;
            flags_o.c = sbx_nob;
            dest_o    = DST_IDX;
         end
         OPC_SBC_ALT: begin
            acc_o     = sbc_diff;
            flags_o.n = sbc_diff[MSB];
            flags_o.z = ~|sbc_diff;
            flags_o.c = sbc_nob;
            flags_o.v = (acc_i[MSB] ^ opnd_i[MSB]) & (acc_i[MSB] ^ sbc_diff[MSB]);
            dest_o    = DST_ACC;
         end
         OPC_LAX: begin
            acc_o     = opnd_i;
            idx_o     = opnd_i;
            flags_o.n = opnd_i[MSB];
            flags_o.z = ~|opnd_i;
            dest_o    = DST_BOTH;
         end
         default: begin
            illegal_o = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/imm_alu_result.sv
module imm_alu_result
   import imm_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] idx_i,
   input  flags_t            flags_i,
   input  dest_e             dest_i,
   input  logic              illegal_i,
   output logic [DATA_W-1:0] acc_o,
   output logic [DATA_W-1:0] idx_o,
   output flags_t            flags_o,
   output dest_e             dest_o,
   output logic              illegal_o,
   output logic              done_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_o     <= '0;
         idx_o     <= '0;
         flags_o   <= '0;
         dest_o    <= DST_NONE;
         illegal_o <= 1'b0;
         done_o    <= 1'b0;
      end else begin
         done_o <= valid_i;
         if (valid_i) begin
            acc_o     <= acc_i;
            idx_o     <= idx_i;
            flags_o   <= flags_i;
            dest_o    <= dest_i;
            illegal_o <= illegal_i;
         end
      end
   end

endmodule

// File: rtl/imm_fused_alu.sv
module imm_fused_alu
   import imm_alu_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit SUB_VIA_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        opcode,
   input  logic [DATA_W-1:0] operand,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] idx_in,
   input  logic              flag_n_in,
   input  logic              flag_v_in,
   input  logic              flag_d_in,
   input  logic              flag_z_in,
   input  logic              flag_c_in,
   output logic [DATA_W-1:0] acc_out,
   output logic [DATA_W-1:0] idx_out,
   output logic              flag_n_out,
   output logic              flag_v_out,
   output logic              flag_d_out,
   output logic              flag_z_out,
   output logic              flag_c_out,
   output logic [1:0]        dest_sel,
   output logic              illegal,
   output logic              done
);

   generate
      if (DATA_W < 3) begin : g_bad_width
         $error("imm_fused_alu: DATA_W must be at least 3");
      end
   endgenerate

   flags_t            flags_in_s;
   logic              cap_valid;
   logic [OPC_W-1:0]  cap_opc;
   logic [DATA_W-1:0] cap_opnd;
   logic [DATA_W-1:0] cap_acc;
   logic [DATA_W-1:0] cap_idx;
   flags_t            cap_flags;
   logic [DATA_W-1:0] nxt_acc;
   logic [DATA_W-1:0] nxt_idx;
   flags_t            nxt_flags;
   dest_e             nxt_dest;
   logic              nxt_ill;
   flags_t            out_flags;
   dest_e             out_dest;

   assign flags_in_s = '{n: flag_n_in, v: flag_v_in, d: flag_d_in, z: flag_z_in, c: flag_c_in};

   imm_alu_capture #(.DATA_W(DATA_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .opc_i   (opcode),
      .opnd_i  (operand),
      .acc_i   (acc_in),
      .idx_i   (idx_in),
      .flags_i (flags_in_s),
      .valid_o (cap_valid),
      .opc_o   (cap_opc),
      .opnd_o  (cap_opnd),
      .acc_o   (cap_acc),
      .idx_o   (cap_idx),
      .flags_o (cap_flags)
   );

   imm_alu_core #(.DATA_W(DATA_W), .SUB_VIA_ADD(SUB_VIA_ADD)) u_core (
      .opc_i     (cap_opc),
      .opnd_i    (cap_opnd),
      .acc_i     (cap_acc),
      .idx_i     (cap_idx),
      .flags_i   (cap_flags),
      .acc_o     (nxt_acc),
      .idx_o     (nxt_idx),
      .flags_o   (nxt_flags),
      .dest_o    (nxt_dest),
      .illegal_o (nxt_ill)
   );

   imm_alu_result #(.DATA_W(DATA_W)) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_i   (cap_valid),
      .acc_i     (nxt_acc),
      .idx_i     (nxt_idx),
      .flags_i   (nxt_flags),
      .dest_i    (nxt_dest),
      .illegal_i (nxt_ill),
      .acc_o     (acc_out),
      .idx_o     (idx_out),
      .flags_o   (out_flags),
      .dest_o    (out_dest),
      .illegal_o (illegal),
      .done_o    (done)
   );

   assign flag_n_out = out_flags.n;
   assign flag_v_out = out_flags.v;
   assign flag_d_out = out_flags.d;
   assign flag_z_out = out_flags.z;
   assign flag_c_out = out_flags.c;
   assign dest_sel   = out_dest;

endmodule

// File: rtl/imm_alu_chk.sv
module imm_alu_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [7:0]        opcode,
   input logic [DATA_W-1:0] acc_in,
   input logic [DATA_W-1:0] idx_in,
   input logic              flag_v_in,
   input logic              flag_d_in,
   input logic [DATA_W-1:0] acc_out,
   input logic [DATA_W-1:0] idx_out,
   input logic              flag_n_out,
   input logic              flag_v_out,
   input logic              flag_d_out,
   input logic              flag_z_out,
   input logic [1:0]        dest_sel,
   input logic              illegal,
   input logic              done
);

   p_done_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start, 2) |-> done);

   p_done_needs_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start, 2));

   p_unknown_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && illegal) |-> (acc_out == $past(acc_in, 2) && idx_out == $past(idx_in, 2)
                             && dest_sel == 2'b00));

   p_shift_n_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(opcode, 2) == 8'h4B) |-> !flag_n_out);

   p_idx_sub_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(opcode, 2) == 8'hCB) |->
         (flag_v_out == $past(flag_v_in, 2) && acc_out == $past(acc_in, 2)));

   p_decimal_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> flag_d_out == $past(flag_d_in, 2));

   p_zero_tracks_acc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && dest_sel == 2'b01) |-> flag_z_out == (acc_out == '0));

   p_hold_between_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(acc_out) && $stable(idx_out) && $stable(dest_sel)));

endmodule

bind imm_fused_alu imm_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .opcode     (opcode),
   .acc_in     (acc_in),
   .idx_in     (idx_in),
   .flag_v_in  (flag_v_in),
   .flag_d_in  (flag_d_in),
   .acc_out    (acc_out),
   .idx_out    (idx_out),
   .flag_n_out (flag_n_out),
   .flag_v_out (flag_v_out),
   .flag_d_out (flag_d_out),
   .flag_z_out (flag_z_out),
   .dest_sel   (dest_sel),
   .illegal    (illegal),
   .done       (done)
);

// File: tb/sim_imm_fused_alu.sv
`timescale 1ns/1ps
module sim_imm_fused_alu;

   localparam int W     = 8;
   localparam int VEC_W = 61;
   localparam int NVEC  = 16;

   // {opcode, M, A, X, flags_in(nvdzc), expA, expX, exp_flags(nvdzc), dest, illegal}
   localparam logic [VEC_W-1:0] VEC [NVEC] = '{
      {8'h0B, 8'h8F, 8'hF0, 8'h11, 5'b00000, 8'h80, 8'h11, 5'b10001, 2'b01, 1'b0},
      {8'h2B, 8'hF0, 8'h0F, 8'h22, 5'b01001, 8'h00, 8'h22, 5'b01010, 2'b01, 1'b0},
      {8'h4B, 8'h03, 8'hFF, 8'h00, 5'b10000, 8'h01, 8'h00, 5'b00001, 2'b01, 1'b0},
      {8'h4B, 8'h01, 8'h01, 8'h05, 5'b00000, 8'h00, 8'h05, 5'b00011, 2'b01, 1'b0},
      {8'h6B, 8'hFF, 8'hFF, 8'h00, 5'b00001, 8'hFF, 8'h00, 5'b10001, 2'b01, 1'b0},
      {8'h6B, 8'hFF, 8'h80, 8'h00, 5'b10100, 8'h40, 8'h00, 5'b01101, 2'b01, 1'b0},
      {8'hCB, 8'h10, 8'hF0, 8'h3C, 5'b01000, 8'hF0, 8'h20, 5'b01001, 2'b10, 1'b0},
      {8'hCB, 8'h06, 8'hFF, 8'h05, 5'b00001, 8'hFF, 8'hFF, 5'b10000, 2'b10, 1'b0},
      {8'hCB, 8'h0F, 8'h0F, 8'h0F, 5'b10000, 8'h0F, 8'h00, 5'b00011, 2'b10, 1'b0},
      {8'hEB, 8'hF0, 8'h50, 8'h77, 5'b00001, 8'h60, 8'h77, 5'b00000, 2'b01, 1'b0},
      {8'hEB, 8'hB0, 8'h50, 8'h77, 5'b00001, 8'hA0, 8'h77, 5'b11000, 2'b01, 1'b0},
      {8'hEB, 8'h0F, 8'h10, 8'h00, 5'b00100, 8'h00, 8'h00, 5'b00111, 2'b01, 1'b0},
      {8'hAB, 8'h80, 8'h12, 8'h34, 5'b00001, 8'h80, 8'h80, 5'b10001, 2'b11, 1'b0},
      {8'hAB, 8'h00, 8'h12, 8'h34, 5'b11000, 8'h00, 8'h00, 5'b01010, 2'b11, 1'b0},
      {8'h02, 8'hFF, 8'h5A, 8'hA5, 5'b11111, 8'h5A, 8'hA5, 5'b11111, 2'b00, 1'b1},
      {8'hEA, 8'h00, 8'h00, 8'h00, 5'b00010, 8'h00, 8'h00, 5'b00010, 2'b00, 1'b1}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [7:0]   opcode = '0;
   logic [W-1:0] operand = '0;
   logic [W-1:0] acc_in = '0;
   logic [W-1:0] idx_in = '0;
   logic         flag_n_in = 1'b0, flag_v_in = 1'b0, flag_d_in = 1'b0;
   logic         flag_z_in = 1'b0, flag_c_in = 1'b0;
   logic [W-1:0] acc_out, idx_out;
   logic         flag_n_out, flag_v_out, flag_d_out, flag_z_out, flag_c_out;
   logic [1:0]   dest_sel;
   logic         illegal, done;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   imm_fused_alu #(.DATA_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .operand(operand),
      .acc_in(acc_in), .idx_in(idx_in),
      .flag_n_in(flag_n_in), .flag_v_in(flag_v_in), .flag_d_in(flag_d_in),
      .flag_z_in(flag_z_in), .flag_c_in(flag_c_in),
      .acc_out(acc_out), .idx_out(idx_out),
      .flag_n_out(flag_n_out), .flag_v_out(flag_v_out), .flag_d_out(flag_d_out),
      .flag_z_out(flag_z_out), .flag_c_out(flag_c_out),
      .dest_sel(dest_sel), .illegal(illegal), .done(done)
   );

   function automatic logic [23:0] observed();
      return {acc_out, idx_out, flag_n_out, flag_v_out, flag_d_out, flag_z_out,
              flag_c_out, dest_sel, illegal};
   endfunction

   function automatic string req_of(logic [7:0] op);
      case (op)
         8'h0B, 8'h2B: return "R1";
         8'h4B:        return "R2";
         8'h6B:        return "R3";
         8'hCB:        return "R4";
         8'hEB:        return "R5";
         8'hAB:        return "R6";
         default:      return "R7";
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(logic [VEC_W-1:0] v);
      opcode  = v[60:53];
      operand = v[52:45];
      acc_in  = v[44:37];
      idx_in  = v[36:29];
      {flag_n_in, flag_v_in, flag_d_in, flag_z_in, flag_c_in} = v[28:24];
      start   = 1'b1;
   endtask

   task automatic scramble();
      opcode  = 8'h0B;
      operand = 8'hC3;
      acc_in  = 8'h3C;
      idx_in  = 8'h99;
      {flag_n_in, flag_v_in, flag_d_in, flag_z_in, flag_c_in} = 5'b01110;
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10", {8'h0, observed(), done}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         apply(VEC[i]);
         @(negedge clk);
         start = 1'b0;
         scramble();
         check("R9", {31'h0, done}, 32'h0);
         @(negedge clk);
         check("R9", {31'h0, done}, 32'h1);
         check(req_of(VEC[i][60:53]), {8'h0, observed()}, {8'h0, VEC[i][23:0]});
         @(negedge clk);
         check("R9", {31'h0, done}, 32'h0);
      end

      // R8: D flag set on an opcode not in any vector above with D=1 (LAX)
      @(negedge clk);
      apply({8'hAB, 8'h7F, 8'h00, 8'h00, 5'b00100, 8'h7F, 8'h7F, 5'b00100, 2'b11, 1'b0});
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check("R8", {8'h0, observed()}, {8'h0, 8'h7F, 8'h7F, 5'b00100, 2'b11, 1'b0});

      // R11: outputs hold while inputs wander with start low
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         scramble();
         acc_in = 8'(k * 37);
         check("R11", {7'h0, observed(), done}, {7'h0, 8'h7F, 8'h7F, 5'b00100, 2'b11, 1'b0, 1'b0});
      end

      // R9: back-to-back starts
      @(negedge clk);
      apply(VEC[0]);
      @(negedge clk);
      apply(VEC[12]);
      @(negedge clk);
      start = 1'b0;
      scramble();
      check("R9", {7'h0, observed(), done}, {7'h0, VEC[0][23:0], 1'b1});
      @(negedge clk);
      check("R9", {7'h0, observed(), done}, {7'h0, VEC[12][23:0], 1'b1});
      @(negedge clk);
      check("R9", {31'h0, done}, 32'h0);

      // R10: reset in the middle of operation clears everything
      @(negedge clk);
      apply(VEC[14]);
      @(negedge clk);
      start = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check("R10", {8'h0, observed(), done}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", {8'h0, observed(), done}, 32'h0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule